// File: doc/BRIEF.md
# DRAM Activate Rate Limiter

This block sits between a memory controller's command scheduler and the command bus of an eight-bank DRAM. In every cycle the scheduler offers one candidate command (activate, read, write or no-op) together with a bank number. The block answers in the same cycle with a grant. It grants only when the command obeys the activate spacing rules: the minimum gap between two activates, the limit of four activates in any rolling window, and the per-bank delay from an activate to the first read or write.

A refused command is kept by the scheduler and offered again later. A refusal leaves all internal timing state untouched. The three timing limits arrive as precomputed clock counts on static configuration inputs, which change only while reset is asserted. A separate input switches the four-activate window off. With the window off, only the gap and column-delay rules apply.

Top module: `act_rate_gate`

## Requirements
- R1: The command encoding is 2'b00 no-op, 2'b01 activate, 2'b10 read and 2'b11 write, and `bank` selects bank 0 to 7. A no-op is always granted and changes no timing state.
- R2: An activate is granted only if at least `rrd_clks` clocks (rrd_clks >= 1) have passed since the previous granted activate. With rrd_clks = 2 and an activate granted in cycle N, an activate in cycle N+1 is refused and one in cycle N+2 may be granted.
- R3: With the window enabled, an activate is refused if four activates were granted within the last `faw_clks` clocks. With faw_clks = 10 and activates granted in cycles N, N+2, N+6 and N+8, the next activate is first granted in cycle N+10.
- R4: With `faw_off` = 1 the window check is skipped. With rrd_clks = 1, activates are granted in every cycle.
- R5: A read or write is granted only if its bank has been activated and at least `rcd_clks` clocks have passed since that bank's latest granted activate. A new activate to the bank restarts this delay.
- R6: After reset no bank counts as activated. Reads and writes are refused until their bank is activated, and the first activate is granted at once.
- R7: A refused command changes no timer. A refused activate neither restarts the gap nor takes a window slot.
- R8: Grant is a combinational answer in the same cycle. An activate affects only its own bank's column delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 2 | Candidate command code |
| bank | input | 3 | Bank of the candidate command |
| faw_clks | input | CW | Rolling window length in clocks |
| rrd_clks | input | CW | Minimum activate-to-activate gap in clocks |
| rcd_clks | input | CW | Activate-to-column delay in clocks |
| faw_off | input | 1 | 1 disables the four-activate window |
| grant | output | 1 | Candidate command may issue this cycle |

## Verification
The hardest case to reach is a fifth activate that meets the gap rule and is refused only by the window. The window blocks an activate only after four activates have been granted and the oldest of them is still inside it. The stimulus table first fills the window with spaced activates. It then offers activates on every cycle until the oldest one ages out, and checks the exact cycle in which the grant returns. A second directed run uses a short window with back-to-back activates. That run shows the window closing and reopening without any effect from the gap rule.

// File: rtl/act_rate_gate.sv
module act_rate_gate #(
  parameter int CW = 6,
  parameter int BW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cmd,
  input  logic [BW-1:0] bank,
  input  logic [CW-1:0] faw_clks,
  input  logic [CW-1:0] rrd_clks,
  input  logic [CW-1:0] rcd_clks,
  input  logic          faw_off,
  output logic          grant
);
  localparam int NB = 1 << BW;
  localparam int NS = 4;

  function automatic logic [CW-1:0] down(input logic [CW-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  logic [CW-1:0] gap_cnt;
  logic [CW-1:0] age [NS];
  logic [1:0]    oldest;
  logic [NB-1:0] opened;
  logic [CW-1:0] col_cnt [NB];

  wire is_nop = (cmd == 2'b00);
  wire is_act = (cmd == 2'b01);
  wire is_col = cmd[1];

  wire win_ok = faw_off || (age[oldest] == '0);
  wire act_go = is_act && (gap_cnt == '0) && win_ok;
  wire col_go = is_col && opened[bank] && (col_cnt[bank] == '0);

  assign grant = is_nop || act_go || col_go;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_cnt <= '0;
      oldest  <= '0;
      opened  <= '0;
      for (int i = 0; i < NS; i++) age[i] <= '0;
      for (int b = 0; b < NB; b++) col_cnt[b] <= '0;
    end else begin
      gap_cnt <= act_go ? down(rrd_clks) : down(gap_cnt);
      if (act_go) oldest <= oldest + 2'd1;
      for (int i = 0; i < NS; i++)
        age[i] <= (act_go && oldest == i[1:0]) ? down(faw_clks) : down(age[i]);
      for (int b = 0; b < NB; b++) begin
        if (act_go && bank == b[BW-1:0]) begin
          col_cnt[b] <= down(rcd_clks);
          opened[b]  <= 1'b1;
        end else begin
          col_cnt[b] <= down(col_cnt[b]);
        end
      end
    end
  end

  logic [NS-1:0] busy;
  always_comb
    for (int i = 0; i < NS; i++) busy[i] = (age[i] != '0);

  // R1
  nop_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_nop |-> grant);

  // R2
  rrd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_go && rrd_clks > CW'(1)) |=> !(is_act && grant));

  // R3
  faw_slots_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_go && !faw_off) |-> ($countones(busy) <= 3));

  // R5
  col_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_go && rcd_clks > CW'(1)) |=> !(is_col && grant && bank == $past(bank)));

  // R6
  col_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_col && !opened[bank]) |-> !grant);
endmodule

// File: tb/sim_act_rate_gate.sv
module sim_act_rate_gate;
  localparam int CW = 6;
  logic clk = 0, rst_n = 0;
  logic [1:0] cmd = 2'b00;
  logic [2:0] bank = 3'd0;
  logic [CW-1:0] faw_clks = 6'd10, rrd_clks = 6'd2, rcd_clks = 6'd3;
  logic faw_off = 0;
  logic grant;
  int checks = 0, fails = 0;

  act_rate_gate #(.CW(CW), .BW(3)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .bank(bank),
    .faw_clks(faw_clks), .rrd_clks(rrd_clks), .rcd_clks(rcd_clks),
    .faw_off(faw_off), .grant(grant));

  always #2 clk = ~clk;

  localparam logic [1:0] NOP = 2'b00, ACT = 2'b01, RD = 2'b10, WR = 2'b11;

  // {cmd, bank, expected grant}; rrd=2, rcd=3, faw=10, window on
  localparam logic [5:0] VEC [22] = '{
    {RD,  3'd0, 1'b0},  // t0  R6 bank closed
    {ACT, 3'd0, 1'b1},  // t1  R6 first act
    {ACT, 3'd1, 1'b0},  // t2  R2 gap
    {ACT, 3'd1, 1'b1},  // t3  R2 R7 gap not restarted
    {RD,  3'd0, 1'b1},  // t4  R5 rcd met
    {RD,  3'd1, 1'b0},  // t5  R5 rcd not met
    {WR,  3'd1, 1'b1},  // t6  R5
    {ACT, 3'd2, 1'b1},  // t7
    {ACT, 3'd3, 1'b0},  // t8  R2
    {ACT, 3'd3, 1'b1},  // t9  fourth act
    {NOP, 3'd5, 1'b1},  // t10 R1
    {ACT, 3'd4, 1'b1},  // t11 R3 oldest (t1) aged out
    {NOP, 3'd0, 1'b1},  // t12 R1
    {ACT, 3'd5, 1'b1},  // t13 R3 oldest (t3) aged out
    {NOP, 3'd0, 1'b1},  // t14
    {ACT, 3'd6, 1'b0},  // t15 R3 window full
    {ACT, 3'd6, 1'b0},  // t16 R3 R7
    {ACT, 3'd6, 1'b1},  // t17 R3 reopens
    {RD,  3'd7, 1'b0},  // t18 R6 never opened
    {RD,  3'd6, 1'b0},  // t19 R5
    {RD,  3'd6, 1'b1},  // t20 R5
    {RD,  3'd2, 1'b1}   // t21 R8 other banks unaffected
  };

  task automatic step(input logic [1:0] c, input logic [2:0] b, input logic exp, input string tag);
    @(negedge clk);
    cmd = c; bank = b;
    #1;
    checks++;
    if (grant !== exp) begin
      fails++;
      $display("FAIL %s: cmd=%0d bank=%0d grant=%b expected %b", tag, c, b, grant, exp);
    end
  endtask

  task automatic do_reset(input logic [CW-1:0] f, input logic [CW-1:0] r, input logic [CW-1:0] c, input logic off);
    @(negedge clk);
    rst_n = 0; cmd = NOP; faw_clks = f; rrd_clks = r; rcd_clks = c; faw_off = off;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: timeout actual=running expected=done");
    finish_run();
  end

  initial begin
    do_reset(6'd10, 6'd2, 6'd3, 1'b0);
    for (int i = 0; i < 22; i++)
      step(VEC[i][5:4], VEC[i][3:1], VEC[i][0], $sformatf("table t%0d", i));

    // R5: re-activating bank 0 restarts its delay
    step(ACT, 3'd0, 1'b1, "R5 reactivate");
    step(RD,  3'd0, 1'b0, "R5 rcd restart");
    step(NOP, 3'd0, 1'b1, "R1 nop");
    step(RD,  3'd0, 1'b1, "R5 rcd after reload");

    // R6: reset closes all banks again
    do_reset(6'd10, 6'd2, 6'd3, 1'b0);
    step(WR,  3'd0, 1'b0, "R6 closed after reset");
    step(ACT, 3'd0, 1'b1, "R6 act after reset");

    // R3: short window, back-to-back activates
    do_reset(6'd5, 6'd1, 6'd1, 1'b0);
    for (int i = 0; i < 4; i++) step(ACT, 3'(i), 1'b1, "R3 fill window");
    step(ACT, 3'd4, 1'b0, "R3 fifth blocked");
    step(ACT, 3'd4, 1'b1, "R3 fifth after window");
    step(RD,  3'd4, 1'b1, "R8 rcd=1 next cycle");

    // R4: window disabled
    do_reset(6'd5, 6'd1, 6'd1, 1'b1);
    for (int i = 0; i < 7; i++) step(ACT, 3'(i), 1'b1, "R4 window off");
    step(WR, 3'd6, 1'b1, "R4 column still timed");

    finish_run();
  end
endmodule